// File: doc/BRIEF.md
# Low-Side Current-Limit Threshold Calibrator

This block sets the current limit that a synchronous step-down converter applies to its low-side switch, and then watches every switching period for overcurrent. After supply-good is reported and the controller is enabled for the first time, the block opens a timed calibration window. In that window it captures one digitized sample of the voltage dropped between the supply rail and the compensation node, divides it by three, and clamps the result to the legal range. That value becomes the limit and stays put until the supply drops out. A separate supply-high flag overrides the calibrated limit with a fixed value while it is asserted.

Once calibration is done, each clock in which the low-side switch is on compares the digitized ground-to-phase drop with the active limit. Any excess seen during a switching period is reported as a single one-clock event pulse just after the next period boundary. The fault sequencer downstream consumes that pulse, and the same sequencer waits for the done flag before it starts a soft-start. All voltages are unsigned millivolt codes.

Top module: `oc_limit_prog`

## Requirements
- R1: After reset, `cal_done` and `oc_event` are 0 and, with `vcc_high` low, `oc_thr` reads THR_MAX (500).
- R2: Calibration starts only on a clock edge where `supply_ok` and `enable_req` are both high while the block is idle. Without that edge, `cal_done` stays 0.
- R3: The calibrated limit is the `drop_code` value sampled SAMPLE_CYC+1 edges after calibration starts, divided by 3 with truncation.
- R4: The calibrated limit is clamped to THR_MIN (50) through THR_MAX (500). A large drop, which is what a missing programming resistor produces, gives THR_MAX.
- R5: `cal_done` rises L edges after the starting edge, where L = WIN_BASE + (limit >> WIN_SHIFT). With the defaults this is 40 + limit/16, so the window scales with the limit.
- R6: While `vcc_high` is 1, `oc_thr` equals THR_FIXED (400) in the same cycle, and comparisons use that value.
- R7: Once `cal_done` is set, the limit is not re-sampled. Lowering and raising `enable_req` or changing `drop_code` has no effect until `supply_ok` falls.
- R8: One edge after `supply_ok` is sampled low, `cal_done` is 0 and the limit returns to THR_MAX. A new enable is then needed to recalibrate.
- R9: A period is flagged when, in any clock of that period, `ls_on` is 1 and `phase_drop` is strictly greater than `oc_thr`. A value equal to `oc_thr` is not an overcurrent.
- R10: Samples with `ls_on` low, and all samples taken while `cal_done` is 0, never produce an event.
- R11: `oc_event` is a one-clock pulse in the clock after the edge that samples `cyc_start` high. It reports the period that ended, at most once. A sample taken on the same edge as `cyc_start` belongs to the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the lockout level |
| enable_req | input | 1 | Controller enable request |
| vcc_high | input | 1 | Supply-high flag; forces the fixed limit |
| drop_code | input | CODE_W | Digitized supply-to-COMP drop, mV |
| phase_drop | input | CODE_W | Digitized ground-to-PHASE drop, mV |
| ls_on | input | 1 | Low-side switch is on |
| cyc_start | input | 1 | Switching-period boundary strobe |
| cal_done | output | 1 | Calibration finished; limit is valid |
| oc_thr | output | CODE_W | Active current limit, mV |
| oc_event | output | 1 | One-clock overcurrent pulse per flagged period |

## Verification
The bench targets several corner cases. At the comparison boundary, a drop equal to the limit must stay quiet; a design that used greater-or-equal would raise a false event. A sample that lands on the same edge as the period strobe must be charged to the new period; a design that merged it into the old one would report the event one period early. Clamping is tested at both ends, including the large drop from a missing resistor. The window length is measured for three limits, so a fixed window or an off-by-one in the count shows up as a wrong done edge. The bench also toggles enable and changes the drop after calibration to catch any re-sampling. It drives heavy overcurrent during calibration to catch a comparator that is armed too early.

// File: rtl/oclp_pkg.sv
package oclp_pkg;
   typedef enum logic [1:0] {
      OCLP_IDLE = 2'd0,
      OCLP_CAL  = 2'd1,
      OCLP_HOLD = 2'd2
   } oclp_state_e;

   function automatic int oclp_win_max(input int base, input int thr_max, input int shift);
      return base + (thr_max >> shift);
   endfunction
endpackage

// File: rtl/oclp_div3_clamp.sv
module oclp_div3_clamp #(
   parameter int CODE_W    = 12,
   parameter int THR_MIN   = 50,
   parameter int THR_MAX   = 500,
   parameter bit USE_RECIP = 1'b1
) (
   input  logic [CODE_W-1:0] drop,
   output logic [CODE_W-1:0] thr
);
   logic [CODE_W-1:0] quot;

   generate
      if (USE_RECIP) begin : g_recip
         // floor(x/3) == (x*ceil(2^K/3)) >> K for every x < 2^(K-1)
         localparam int K    = CODE_W + 1;
         localparam int PW   = CODE_W + K + 1;
         localparam int MULT = ((1 << K) + 2) / 3;
         logic [PW-1:0] prod;
         assign prod = PW'(drop) * PW'(MULT);
         assign quot = prod[K +: CODE_W];
      end else begin : g_const
         assign quot = drop / CODE_W'(3);
      end
   endgenerate

   always_comb begin
      if (quot > CODE_W'(THR_MAX))      thr = CODE_W'(THR_MAX);
      else if (quot < CODE_W'(THR_MIN)) thr = CODE_W'(THR_MIN);
      else                              thr = quot;
   end
endmodule

// File: rtl/oclp_cal_seq.sv
module oclp_cal_seq
   import oclp_pkg::*;
#(
   parameter int CODE_W     = 12,
   parameter int THR_MIN    = 50,
   parameter int THR_MAX    = 500,
   parameter int WIN_BASE   = 40,
   parameter int WIN_SHIFT  = 4,
   parameter int SAMPLE_CYC = 8,
   parameter bit USE_RECIP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              enable_req,
   input  logic [CODE_W-1:0] drop_code,
   output logic [CODE_W-1:0] held_thr,
   output logic              cal_done
);
   localparam int WIN_MAX = oclp_win_max(WIN_BASE, THR_MAX, WIN_SHIFT);
   localparam int CNT_W   = $clog2(WIN_MAX + 1);

   oclp_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  win_last;
   logic [CODE_W-1:0] thr_calc;

   oclp_div3_clamp #(
      .CODE_W   (CODE_W),
      .THR_MIN  (THR_MIN),
      .THR_MAX  (THR_MAX),
      .USE_RECIP(USE_RECIP)
   ) u_div (
      .drop(drop_code),
      .thr (thr_calc)
   );

   assign win_last = CNT_W'(WIN_BASE - 1) + CNT_W'(held_thr >> WIN_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= OCLP_IDLE;
         cnt      <= '0;
         held_thr <= CODE_W'(THR_MAX);
         cal_done <= 1'b0;
      end else if (!supply_ok) begin
         state    <= OCLP_IDLE;
         cnt      <= '0;
         held_thr <= CODE_W'(THR_MAX);
         cal_done <= 1'b0;
      end else begin
         case (state)
            OCLP_IDLE: begin
               cnt <= '0;
               if (enable_req) state <= OCLP_CAL;
            end
            OCLP_CAL: begin
               if (cnt == CNT_W'(SAMPLE_CYC)) held_thr <= thr_calc;
               if (cnt == win_last) begin
                  state    <= OCLP_HOLD;
                  cal_done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            OCLP_HOLD: begin
               cal_done <= 1'b1;
            end
            default: state <= OCLP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/oclp_event_det.sv
module oclp_event_det #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              ls_on,
   input  logic              cyc_start,
   input  logic [CODE_W-1:0] phase_drop,
   input  logic [CODE_W-1:0] thr,
   output logic              oc_event
);
   logic hit_q;
   logic over_now;

   assign over_now = armed && ls_on && (phase_drop > thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q    <= 1'b0;
         oc_event <= 1'b0;
      end else begin
         oc_event <= armed && cyc_start && hit_q;
         if (!armed)         hit_q <= 1'b0;
         else if (cyc_start) hit_q <= over_now;
         else                hit_q <= hit_q | over_now;
      end
   end
endmodule

// File: rtl/oc_limit_prog.sv
module oc_limit_prog #(
   parameter int CODE_W     = 12,
   parameter int THR_MIN    = 50,
   parameter int THR_MAX    = 500,
   parameter int THR_FIXED  = 400,
   parameter int WIN_BASE   = 40,
   parameter int WIN_SHIFT  = 4,
   parameter int SAMPLE_CYC = 8,
   parameter bit USE_RECIP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              enable_req,
   input  logic              vcc_high,
   input  logic [CODE_W-1:0] drop_code,
   input  logic [CODE_W-1:0] phase_drop,
   input  logic              ls_on,
   input  logic              cyc_start,
   output logic              cal_done,
   output logic [CODE_W-1:0] oc_thr,
   output logic              oc_event
);
   generate
      if (THR_MIN > THR_MAX) begin : g_err_range
         $error("oc_limit_prog: THR_MIN above THR_MAX");
      end
      if (THR_MAX >= (1 << CODE_W)) begin : g_err_width
         $error("oc_limit_prog: THR_MAX does not fit CODE_W");
      end
      if (THR_FIXED < THR_MIN || THR_FIXED > THR_MAX) begin : g_err_fixed
         $error("oc_limit_prog: THR_FIXED outside range");
      end
      if (SAMPLE_CYC >= WIN_BASE - 1) begin : g_err_sample
         $error("oc_limit_prog: sample point must precede window end");
      end
   endgenerate

   logic [CODE_W-1:0] held_thr;

   oclp_cal_seq #(
      .CODE_W    (CODE_W),
      .THR_MIN   (THR_MIN),
      .THR_MAX   (THR_MAX),
      .WIN_BASE  (WIN_BASE),
      .WIN_SHIFT (WIN_SHIFT),
      .SAMPLE_CYC(SAMPLE_CYC),
      .USE_RECIP (USE_RECIP)
   ) u_cal (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .enable_req(enable_req),
      .drop_code (drop_code),
      .held_thr  (held_thr),
      .cal_done  (cal_done)
   );

   assign oc_thr = vcc_high ? CODE_W'(THR_FIXED) : held_thr;

   oclp_event_det #(
      .CODE_W(CODE_W)
   ) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (cal_done),
      .ls_on     (ls_on),
      .cyc_start (cyc_start),
      .phase_drop(phase_drop),
      .thr       (oc_thr),
      .oc_event  (oc_event)
   );
endmodule

// File: rtl/oclp_checker.sv
module oclp_checker #(
   parameter int CODE_W    = 12,
   parameter int THR_MIN   = 50,
   parameter int THR_MAX   = 500,
   parameter int THR_FIXED = 400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              supply_ok,
   input logic              vcc_high,
   input logic              cyc_start,
   input logic              cal_done,
   input logic [CODE_W-1:0] oc_thr,
   input logic              oc_event
);
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !cal_done); // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && supply_ok) |=> cal_done); // R7

   AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && $past(cal_done) && !vcc_high && !$past(vcc_high)) |-> $stable(oc_thr)); // R7

   AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_high |-> (oc_thr >= CODE_W'(THR_MIN) && oc_thr <= CODE_W'(THR_MAX))); // R4

   AST_FIXED_THR: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_high |-> (oc_thr == CODE_W'(THR_FIXED))); // R6

   AST_EVENT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      oc_event |-> $past(cyc_start)); // R11

   AST_EVENT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      oc_event |-> $past(cal_done)); // R10
endmodule

bind oc_limit_prog oclp_checker #(
   .CODE_W   (CODE_W),
   .THR_MIN  (THR_MIN),
   .THR_MAX  (THR_MAX),
   .THR_FIXED(THR_FIXED)
) u_oclp_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .supply_ok(supply_ok),
   .vcc_high (vcc_high),
   .cyc_start(cyc_start),
   .cal_done (cal_done),
   .oc_thr   (oc_thr),
   .oc_event (oc_event)
);

// File: tb/oc_limit_prog_bench.sv
module oc_limit_prog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 12;
   localparam int T_MIN      = 50;
   localparam int T_MAX      = 500;
   localparam int T_FIX      = 400;
   localparam int W_BASE     = 40;
   localparam int W_SHIFT    = 4;
   localparam int S_CYC      = 8;
   localparam int WD_LIMIT   = 50000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              supply_ok = 1'b0;
   logic              enable_req = 1'b0;
   logic              vcc_high = 1'b0;
   logic [CODE_W-1:0] drop_code = '0;
   logic [CODE_W-1:0] phase_drop = '0;
   logic              ls_on = 1'b0;
   logic              cyc_start = 1'b0;
   logic              cal_done;
   logic [CODE_W-1:0] oc_thr;
   logic              oc_event;

   int n_cmp = 0;
   int n_bad = 0;
   int wd = 0;
   string cur_req = "R1";

   oc_limit_prog u_oc_limit_prog (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable_req(enable_req),
      .vcc_high(vcc_high), .drop_code(drop_code), .phase_drop(phase_drop),
      .ls_on(ls_on), .cyc_start(cyc_start), .cal_done(cal_done),
      .oc_thr(oc_thr), .oc_event(oc_event)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_phase = 0;   // 0 idle, 1 calibrating, 2 holding
   int m_cnt = 0;
   int m_limit = T_MAX;
   int m_done = 0;
   int m_hit = 0;
   int m_ev = 0;

   function automatic int lim_of(input int d);
      int q = d / 3;
      if (q > T_MAX) q = T_MAX;
      if (q < T_MIN) q = T_MIN;
      return q;
   endfunction

   function automatic int act_thr();
      return vcc_high ? T_FIX : m_limit;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_limit = T_MAX; m_done = 0; m_hit = 0; m_ev = 0;
      end else begin
         int over, nx_hit, nx_ev, nx_phase, nx_cnt, nx_limit, nx_done;
         over   = (m_done != 0 && ls_on && int'(phase_drop) > act_thr()) ? 1 : 0;
         nx_ev  = (m_done != 0 && cyc_start && m_hit != 0) ? 1 : 0;
         if (m_done == 0)    nx_hit = 0;
         else if (cyc_start) nx_hit = over;
         else                nx_hit = (m_hit != 0 || over != 0) ? 1 : 0;
         nx_phase = m_phase; nx_cnt = m_cnt; nx_limit = m_limit; nx_done = m_done;
         if (!supply_ok) begin
            nx_phase = 0; nx_cnt = 0; nx_limit = T_MAX; nx_done = 0;
         end else if (m_phase == 0) begin
            nx_cnt = 0;
            if (enable_req) nx_phase = 1;
         end else if (m_phase == 1) begin
            if (m_cnt == S_CYC) nx_limit = lim_of(int'(drop_code));
            if (m_cnt == W_BASE - 1 + (m_limit >> W_SHIFT)) begin
               nx_phase = 2; nx_done = 1;
            end else begin
               nx_cnt = m_cnt + 1;
            end
         end
         m_phase = nx_phase; m_cnt = nx_cnt; m_limit = nx_limit; m_done = nx_done;
         m_hit = nx_hit; m_ev = nx_ev;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      check(cur_req, "cal_done vs model", int'(cal_done), m_done);
      check(cur_req, "oc_event vs model", int'(oc_event), m_ev);
      check(cur_req, "oc_thr vs model", int'(oc_thr), act_thr());
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wait_done(input bit noisy, output int n);
      n = 0;
      while (!cal_done && n < 300) begin
         if (noisy) begin
            cyc_start  = (n % 8 == 0);
            ls_on      = 1'b1;
            phase_drop = 12'd4000;
         end
         tick();
         n++;
         if (noisy) check("R10", "event while calibrating", int'(oc_event), 0);
      end
      cyc_start = 1'b0; ls_on = 1'b0; phase_drop = '0;
   endtask

   // one switching period: boundary, then low-side on for len clocks at drop pd
   task automatic period(input int len, input int pd);
      cyc_start = 1'b1; tick();
      cyc_start = 1'b0;
      ls_on = 1'b1; phase_drop = CODE_W'(pd);
      ticks(len);
      ls_on = 1'b0; phase_drop = '0;
      ticks(2);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > WD_LIMIT) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, WD_LIMIT);
         finish_run();
      end
   end

   initial begin
      int n;
      ticks(3);
      rst_n = 1'b1;
      tick();
      cur_req = "R1";
      check("R1", "reset done", int'(cal_done), 0);
      check("R1", "reset event", int'(oc_event), 0);
      check("R1", "reset thr", int'(oc_thr), T_MAX);

      // R2: supply alone does not start calibration
      cur_req = "R2";
      supply_ok = 1'b1; drop_code = 12'd900;
      ticks(80);
      check("R2", "no enable no done", int'(cal_done), 0);

      // R3/R5: drop 900 -> 300, window 40 + 18 = 58 edges
      cur_req = "R5";
      enable_req = 1'b1;
      wait_done(1'b0, n);
      check("R5", "window ticks thr 300", n, 59);
      check("R3", "limit from 900", int'(oc_thr), 300);

      // R9/R10/R11: events against 300
      cur_req = "R9";
      period(3, 301);
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R9", "above limit flagged", int'(oc_event), 1);
      tick();
      check("R11", "single pulse", int'(oc_event), 0);
      ls_on = 1'b1; phase_drop = 12'd300; ticks(3); ls_on = 1'b0; ticks(1);
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R9", "equal not flagged", int'(oc_event), 0);
      cur_req = "R10";
      phase_drop = 12'd1000; ticks(3); phase_drop = '0;
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R10", "ls off ignored", int'(oc_event), 0);
      cur_req = "R11";
      ticks(2);
      ls_on = 1'b1; phase_drop = 12'd700; cyc_start = 1'b1; tick();
      check("R11", "coincident sample not in old period", int'(oc_event), 0);
      cyc_start = 1'b0; ls_on = 1'b0; phase_drop = '0; ticks(3);
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R11", "coincident sample in new period", int'(oc_event), 1);
      ticks(2);

      // R6: supply-high override
      cur_req = "R6";
      vcc_high = 1'b1;
      #1;
      check("R6", "fixed limit same cycle", int'(oc_thr), T_FIX);
      period(2, 350);
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R6", "350 under fixed 400", int'(oc_event), 0);
      ls_on = 1'b1; phase_drop = 12'd450; tick(); ls_on = 1'b0; phase_drop = '0;
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R6", "450 over fixed 400", int'(oc_event), 1);
      vcc_high = 1'b0; ticks(2);

      // R7: no re-sampling after done
      cur_req = "R7";
      enable_req = 1'b0; drop_code = 12'd2000; ticks(60);
      enable_req = 1'b1; ticks(100);
      check("R7", "limit kept", int'(oc_thr), 300);
      check("R7", "done kept", int'(cal_done), 1);

      // R8: supply drop clears
      cur_req = "R8";
      supply_ok = 1'b0; tick();
      check("R8", "done cleared", int'(cal_done), 0);
      check("R8", "limit back to max", int'(oc_thr), T_MAX);
      enable_req = 1'b0; ticks(3);
      supply_ok = 1'b1; ticks(20);
      check("R8", "needs new enable", int'(cal_done), 0);

      // R4 upper clamp: 3000 -> 1000 -> 500, window 40 + 31, with noise (R10)
      cur_req = "R4";
      drop_code = 12'd3000; enable_req = 1'b1;
      wait_done(1'b1, n);
      check("R5", "window ticks thr 500", n, 72);
      check("R4", "upper clamp", int'(oc_thr), T_MAX);
      ticks(4);

      // R4 lower clamp: 60 -> 20 -> 50, window 40 + 3
      supply_ok = 1'b0; enable_req = 1'b0; ticks(2);
      supply_ok = 1'b1; drop_code = 12'd60; enable_req = 1'b1;
      wait_done(1'b0, n);
      check("R5", "window ticks thr 50", n, 44);
      check("R4", "lower clamp", int'(oc_thr), T_MIN);
      period(2, 51);
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      check("R9", "51 over 50", int'(oc_event), 1);
      ticks(4);

      finish_run();
   end
endmodule